// File: doc/BRIEF.md
# Block-Framed Serial Receiver

This block turns an asynchronous serial line into bytes for a host. It samples the line on a tick running at sixteen times the bit rate and settles every bit by a two-of-three vote over the samples taken in the middle of that bit. Bytes are grouped into blocks of programmable length. A four-entry store collects them and hands them to the host only at block boundaries. The store raises a full event after every fourth byte and a packet-end event on the last byte of the block. The host must then empty the store completely before more bytes may enter.

The receiver flags parity, framing, overrun and block-check (CRC-CCITT) errors and keeps each flag set until the host clears the flags with a pulse. In addressed mode, each character carries a ninth marker bit. A marked character whose value equals the station address opens reception of the following block. Everything else is discarded until a match arrives. The open condition closes once the host has emptied that block.

Top module: `pkt_uart_rx`

## Requirements
- R1: The value of each bit is the two-of-three majority of the line samples at oversampling indices 7, 8 and 9 of the 16 ticks of that bit (index 0 being the first tick of the bit). A single disturbed sample does not change the bit.
- R2: A falling line starts a character only if the majority at the middle of the start bit is low. Otherwise the receiver returns to idle and stores nothing.
- R3: A character is a low start bit, then 8 data bits least significant first, then the marker bit (only when `wake_en`=1), then the parity bit (only when `par_en`=1), then a stop bit. When both `par_en` and `crc_en` are 1, parity applies and no check bytes are expected.
- R4: The block length is `blk_m`+1 bytes. For lengths 1 to 3, `pkt_end` and `irq` rise only once the whole block is stored.
- R5: For lengths of 4 or more, `buf_full` rises each time the store holds 4 bytes, and `pkt_end` rises on the last byte. When the length is a multiple of 4, both rise together on the last byte.
- R6: While `pkt_end` or `buf_full` is set, no byte enters the store. Both flags and `irq` clear when the host has read every stored byte. A `rd_pop` given before either event has no effect. `rd_data` shows the oldest stored byte, and bytes leave in arrival order.
- R7: A block byte that arrives while the store is waiting to be emptied is dropped, and `ovr_err` is set.
- R8: A byte with a parity error (`par_even`=1: the data bits and the parity bit have an even number of ones; `par_even`=0: odd) or with a low stop bit is still stored, and `par_err` or `frm_err` is set.
- R9: With CRC checking active, two check bytes (high byte first) follow the data bytes. They are not stored. After the second check byte, `crc_err` is set if the CRC-CCITT (polynomial x^16+x^12+x^5+1, start value FFFF hex, data bits taken most significant first) over the data and check bytes is not zero.
- R10: The four error flags stay set until an `err_clr` pulse, which clears all of them on the next cycle. Reception goes on while any flag is set.
- R11: With `wake_en`=1 and no block open, a character is taken only if its marker bit is 1 and its data equals `station`. That character opens the block (`wake_hold`=1) and is not stored. All other characters are ignored.
- R12: `wake_hold` returns to 0 after the whole opened block, check bytes included, has been received and the host has emptied the store. Addressed mode stays selected.
- R13: While `rx_en`=0 the receiver stays idle and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| crc_en | input | 1 | Block check bytes present (when parity is off) |
| wake_en | input | 1 | Addressed mode with marker bit |
| blk_m | input | 6 | Block length minus one |
| station | input | 8 | Station address for addressed mode |
| rd_pop | input | 1 | Host read strobe, removes the oldest byte |
| err_clr | input | 1 | Error flag clear pulse |
| rd_data | output | 8 | Oldest stored byte |
| pkt_end | output | 1 | Block complete in store |
| buf_full | output | 1 | Store holds four bytes |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |
| crc_err | output | 1 | Sticky block check error |
| wake_hold | output | 1 | Addressed block currently open |
| irq | output | 1 | Service request, high while the store waits to be emptied |

## Verification
The properties assume that `rxd` and `tick` change only with the clock, and that the host raises `rd_pop` only to drain. They also assume that `wake_en` is steady while a block is in flight. The bench drives the line from a task that changes `rxd` just after a tick edge and holds each bit for exactly sixteen ticks. It changes configuration only between characters, and resets the block between directed tests so that block position starts at zero. Disturbed samples are placed at chosen tick indices to probe the voting window and the start check.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int OSR_DEF = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_BITS,
        SH_STOP
    } sh_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       wbit;
        logic       par_bad;
        logic       frm_bad;
    } rx_char_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/rxb_sampler.sv
module rxb_sampler
    import rxb_pkg::*;
#(
    parameter int OSR = OSR_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     rxd,
    input  logic     wake_on,
    input  logic     par_on,
    input  logic     par_even,
    output logic     char_vld,
    output rx_char_t char_q,
    output logic     busy
);
    localparam int CW = $clog2(OSR);
    localparam int S1 = OSR / 2 - 1;
    localparam int S2 = OSR / 2;
    localparam int S3 = OSR / 2 + 1;

    sh_state_e     st;
    logic [CW-1:0] cnt;
    logic [3:0]    bidx;
    logic [9:0]    shreg;
    logic          s_a, s_b;
    logic          vote, mid, last;
    logic [3:0]    nbits;
    rx_char_t      built;
    logic          pbit;

    assign vote  = maj3(s_a, s_b, rxd);
    assign mid   = (cnt == CW'(S3));
    assign last  = (cnt == CW'(OSR - 1));
    assign nbits = 4'd8 + {3'b000, wake_on} + {3'b000, par_on};
    assign busy  = (st != SH_IDLE);

    always_comb begin
        pbit          = wake_on ? shreg[9] : shreg[8];
        built.data    = shreg[7:0];
        built.wbit    = wake_on & shreg[8];
        built.par_bad = par_on & ((^shreg[7:0]) ^ pbit ^ ~par_even);
        built.frm_bad = ~vote;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= SH_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            s_a      <= 1'b1;
            s_b      <= 1'b1;
            char_vld <= 1'b0;
            char_q   <= '0;
        end else begin
            char_vld <= 1'b0;
            if (tick) begin
                if (cnt == CW'(S1)) s_a <= rxd;
                if (cnt == CW'(S2)) s_b <= rxd;
                unique case (st)
                    SH_IDLE: begin
                        if (!rxd) begin
                            st  <= SH_START;
                            cnt <= CW'(1);
                        end else begin
                            cnt <= '0;
                        end
                    end
                    SH_START: begin
                        if (mid && vote) begin
                            st  <= SH_IDLE;
                            cnt <= '0;
                        end else if (last) begin
                            st   <= SH_BITS;
                            bidx <= '0;
                            cnt  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SH_BITS: begin
                        if (mid) shreg[bidx] <= vote;
                        if (last) begin
                            cnt <= '0;
                            if (bidx == nbits - 4'd1) st <= SH_STOP;
                            else                      bidx <= bidx + 4'd1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SH_STOP: begin
                        if (mid) begin
                            char_q   <= built;
                            char_vld <= 1'b1;
                            st       <= SH_IDLE;
                            cnt      <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= SH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxb_crc.sv
module rxb_crc
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic       zero_next
);
    logic [15:0] crc_q, crc_d;

    assign crc_d     = crc_byte(crc_q, din);
    assign zero_next = (crc_d == 16'h0000);

    always_ff @(posedge clk) begin
        if (rst || clr)  crc_q <= CRC_INIT;
        else if (upd)    crc_q <= crc_d;
    end
endmodule

// File: rtl/rxb_blkctl.sv
module rxb_blkctl
    import rxb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 6,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             char_vld,
    input  rx_char_t         char_in,
    input  logic [LEN_W-1:0] blk_m,
    input  logic             crc_on,
    input  logic             wake_on,
    input  logic [7:0]       station,
    input  logic             rd_pop,
    input  logic             err_clr,
    input  logic             crc_zero,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic [7:0]       rd_data,
    output logic             pkt_end,
    output logic             buf_full,
    output logic             par_err,
    output logic             frm_err,
    output logic             ovr_err,
    output logic             crc_err,
    output logic             wake_hold,
    output logic             lock,
    output logic [CNTW-1:0]  fifo_cnt
);
    localparam int PW = LEN_W + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [PW-1:0] pos;
    logic          done_seen;
    logic          take, addr_hit, last_data, in_check, last_char, push, pop;

    assign take      = char_vld && (!wake_on || wake_hold);
    assign addr_hit  = char_vld && wake_on && !wake_hold && char_in.wbit
                       && (char_in.data == station);
    assign last_data = (pos == PW'(blk_m));
    assign in_check  = (pos > PW'(blk_m));
    assign last_char = crc_on ? (pos == PW'(blk_m) + PW'(2)) : last_data;
    assign push      = take && !in_check && !lock;
    assign pop       = rd_pop && lock && (fifo_cnt != '0);
    assign crc_upd   = take;
    assign crc_clr   = take && last_char;
    assign rd_data   = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= char_in.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; fifo_cnt <= '0; pos <= '0;
            lock <= 1'b0; pkt_end <= 1'b0; buf_full <= 1'b0;
            par_err <= 1'b0; frm_err <= 1'b0; ovr_err <= 1'b0; crc_err <= 1'b0;
            wake_hold <= 1'b0; done_seen <= 1'b0;
        end else begin
            if (push) begin
                wp       <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
                fifo_cnt <= fifo_cnt + 1'b1;
                if (fifo_cnt == CNTW'(DEPTH - 1)) begin
                    buf_full <= 1'b1;
                    lock     <= 1'b1;
                end
                if (last_data) begin
                    pkt_end <= 1'b1;
                    lock    <= 1'b1;
                end
            end
            if (pop) begin
                rp       <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
                fifo_cnt <= fifo_cnt - 1'b1;
                if (fifo_cnt == CNTW'(1)) begin
                    lock     <= 1'b0;
                    pkt_end  <= 1'b0;
                    buf_full <= 1'b0;
                end
            end
            if (take) pos <= last_char ? '0 : pos + 1'b1;
            if (take && lock && !in_check) ovr_err <= 1'b1;
            if (take && char_in.par_bad)   par_err <= 1'b1;
            if (take && char_in.frm_bad)   frm_err <= 1'b1;
            if (take && last_char && crc_on && !crc_zero) crc_err <= 1'b1;
            if (addr_hit) wake_hold <= 1'b1;
            if (take && last_char && wake_hold) done_seen <= 1'b1;
            if (!wake_on) begin
                wake_hold <= 1'b0;
                done_seen <= 1'b0;
            end else if (done_seen && !lock && !char_vld) begin
                wake_hold <= 1'b0;
                done_seen <= 1'b0;
            end
            if (err_clr) begin
                par_err <= 1'b0; frm_err <= 1'b0;
                ovr_err <= 1'b0; crc_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx
    import rxb_pkg::*;
#(
    parameter int OSR   = OSR_DEF,
    parameter int DEPTH = 4,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic             tick,
    input  logic             rx_en,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             crc_en,
    input  logic             wake_en,
    input  logic [LEN_W-1:0] blk_m,
    input  logic [7:0]       station,
    input  logic             rd_pop,
    input  logic             err_clr,
    output logic [7:0]       rd_data,
    output logic             pkt_end,
    output logic             buf_full,
    output logic             par_err,
    output logic             frm_err,
    output logic             ovr_err,
    output logic             crc_err,
    output logic             wake_hold,
    output logic             irq
);
    localparam int CNTW = $clog2(DEPTH + 1);

    rx_char_t        ch;
    logic            ch_vld, rx_busy, crc_on, crc_clr, crc_upd, crc_zero, lock;
    logic [CNTW-1:0] fifo_cnt;

    assign crc_on = crc_en & ~par_en;
    assign irq    = pkt_end | buf_full;

    rxb_sampler #(.OSR(OSR)) u_smp (
        .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .rxd(rxd),
        .wake_on(wake_en), .par_on(par_en), .par_even(par_even),
        .char_vld(ch_vld), .char_q(ch), .busy(rx_busy)
    );

    rxb_crc u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .upd(crc_upd),
        .din(ch.data), .zero_next(crc_zero)
    );

    rxb_blkctl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_blk (
        .clk(clk), .rst(rst), .char_vld(ch_vld), .char_in(ch),
        .blk_m(blk_m), .crc_on(crc_on), .wake_on(wake_en), .station(station),
        .rd_pop(rd_pop), .err_clr(err_clr), .crc_zero(crc_zero),
        .crc_clr(crc_clr), .crc_upd(crc_upd), .rd_data(rd_data),
        .pkt_end(pkt_end), .buf_full(buf_full), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .crc_err(crc_err),
        .wake_hold(wake_hold), .lock(lock), .fifo_cnt(fifo_cnt)
    );
endmodule

// File: rtl/pkt_uart_rx_chk.sv
module pkt_uart_rx_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          wake_en,
    input logic          rd_pop,
    input logic          err_clr,
    input logic          irq,
    input logic          buf_full,
    input logic          par_err,
    input logic          ovr_err,
    input logic          wake_hold,
    input logic          rx_busy,
    input logic [CW-1:0] fifo_cnt
);
    a_r6_locked_no_growth: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_pop) |=> $stable(fifo_cnt));

    a_r5_full_at_depth: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> (fifo_cnt == CW'(DEPTH)));

    a_r10_par_sticky: assert property (@(posedge clk) disable iff (rst)
        (par_err && !err_clr) |=> par_err);

    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_err && !err_clr) |=> ovr_err);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (!par_err && !ovr_err));

    a_r7_overrun_when_waiting: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> $past(irq));

    a_r13_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_busy);

    a_r12_hold_drop_drained: assert property (@(posedge clk) disable iff (rst)
        ($fell(wake_hold) && $past(wake_en)) |-> (fifo_cnt == '0));

    a_r11_hold_needs_mode: assert property (@(posedge clk) disable iff (rst)
        !wake_en |=> !wake_hold);
endmodule

bind pkt_uart_rx pkt_uart_rx_chk u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .wake_en(wake_en), .rd_pop(rd_pop),
    .err_clr(err_clr), .irq(irq), .buf_full(buf_full), .par_err(par_err),
    .ovr_err(ovr_err), .wake_hold(wake_hold), .rx_busy(rx_busy),
    .fifo_cnt(fifo_cnt)
);

// File: tb/tb_pkt_uart_rx.sv
`timescale 1ns/100ps
module tb_pkt_uart_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1, par_en = 1'b0, par_even = 1'b1, crc_en = 1'b0, wake_en = 1'b0;
    logic [5:0] blk_m = '0;
    logic [7:0] station = 8'h5A;
    logic       rd_pop = 1'b0, err_clr = 1'b0;
    logic [7:0] rd_data;
    logic       pkt_end, buf_full, par_err, frm_err, ovr_err, crc_err, wake_hold, irq;
    logic [1:0] tdiv = '0;
    logic       tick;
    int         n_chk = 0, n_fail = 0;
    int         g_bit = -1, g_pos = -1;

    always #2.5 clk = ~clk;
    always @(negedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd3);

    pkt_uart_rx dut (
        .clk(clk), .rst(rst), .rxd(rxd), .tick(tick), .rx_en(rx_en),
        .par_en(par_en), .par_even(par_even), .crc_en(crc_en), .wake_en(wake_en),
        .blk_m(blk_m), .station(station), .rd_pop(rd_pop), .err_clr(err_clr),
        .rd_data(rd_data), .pkt_end(pkt_end), .buf_full(buf_full),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
        .crc_err(crc_err), .wake_hold(wake_hold), .irq(irq)
    );

    // {data, par_en, even, wrong parity sent, stop level, expect par_err, expect frm_err}
    localparam logic [13:0] VEC [8] = '{
        {8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic even);
        return (^d) ^ ~even;
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic wait_tick();
        @(posedge clk);
        while (!tick) @(posedge clk);
    endtask

    task automatic send_bit(input logic v, input int gp);
        for (int i = 0; i < 16; i++) begin
            rxd = (i == gp) ? ~v : v;
            wait_tick();
            #1;
        end
    endtask

    task automatic send_char(input logic [7:0] d, input logic w, input logic p, input logic sv);
        logic [12:0] bits;
        int n;
        bits = '1;
        n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < 8; i++) begin bits[n] = d[i]; n++; end
        if (wake_en) begin bits[n] = w; n++; end
        if (par_en)  begin bits[n] = p; n++; end
        bits[n] = sv; n++;
        bits[n] = 1'b1; n++;
        for (int b = 0; b < n; b++) send_bit(bits[b], (b == g_bit) ? g_pos : -1);
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic send_ok(input logic [7:0] d);
        send_char(d, 1'b0, par_of(d, par_even), 1'b1);
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(posedge clk); #1;
        rd_pop = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(posedge clk); #1;
        err_clr = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; rxd = 1'b1; rx_en = 1'b1; par_en = 1'b0; par_even = 1'b1;
        crc_en = 1'b0; wake_en = 1'b0; blk_m = '0; g_bit = -1; g_pos = -1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] crc;
        do_reset();
        // Reset state
        check("reset irq R6", {15'd0, irq}, 16'd0);
        check("reset flags R10", {12'd0, par_err, frm_err, ovr_err, crc_err}, 16'd0);
        check("reset wake_hold R11", {15'd0, wake_hold}, 16'd0);

        // Vector table: single-byte blocks, parity and framing (R3, R4, R8, R10)
        for (int v = 0; v < 8; v++) begin
            par_en   = VEC[v][5];
            par_even = VEC[v][4];
            send_char(VEC[v][13:6], 1'b0, par_of(VEC[v][13:6], VEC[v][4]) ^ VEC[v][3], VEC[v][2]);
            check("vec pkt_end R4", {15'd0, pkt_end}, 16'd1);
            check("vec data R3", {8'd0, rd_data}, {8'd0, VEC[v][13:6]});
            check("vec par_err R8", {15'd0, par_err}, {15'd0, VEC[v][1]});
            check("vec frm_err R8", {15'd0, frm_err}, {15'd0, VEC[v][0]});
            pop();
            check("vec drained R6", {15'd0, irq}, 16'd0);
            pulse_clr();
            check("vec cleared R10", {14'd0, par_err, frm_err}, 16'd0);
        end

        // R1: one disturbed sample inside the voting window
        do_reset();
        g_bit = 1; g_pos = 8;
        send_ok(8'hA5);
        g_bit = 3; g_pos = 9;
        check("R1 vote data", {8'd0, rd_data}, 16'h00A5);
        pop();
        send_ok(8'h5A);
        check("R1 vote data2", {8'd0, rd_data}, 16'h005A);
        pop();
        g_bit = -1; g_pos = -1;

        // R2: short low pulse rejected
        rxd = 1'b0;
        repeat (3) wait_tick();
        #1 rxd = 1'b1;
        repeat (200) @(posedge clk);
        #1;
        check("R2 false start", {15'd0, irq}, 16'd0);
        send_ok(8'h3C);
        check("R2 next char", {8'd0, rd_data}, 16'h003C);
        pop();
        check("R2 single byte", {15'd0, irq}, 16'd0);

        // R5: length 6
        do_reset();
        blk_m = 6'd5;
        for (int i = 0; i < 4; i++) send_ok(8'h10 + 8'(i));
        check("R5 buf_full", {14'd0, buf_full, pkt_end}, 16'b10);
        for (int i = 0; i < 4; i++) begin
            check("R6 order", {8'd0, rd_data}, {8'd0, 8'h10 + 8'(i)});
            pop();
        end
        check("R6 release", {15'd0, irq}, 16'd0);
        send_ok(8'h14);
        check("R4 not yet", {15'd0, irq}, 16'd0);
        send_ok(8'h15);
        check("R5 last pkt_end", {14'd0, buf_full, pkt_end}, 16'b01);
        pop(); pop();

        // R5: length 4 sets both flags
        do_reset();
        blk_m = 6'd3;
        for (int i = 0; i < 3; i++) send_ok(8'h20 + 8'(i));
        check("R5 partial", {15'd0, irq}, 16'd0);
        send_ok(8'h23);
        check("R5 both", {14'd0, buf_full, pkt_end}, 16'b11);
        for (int i = 0; i < 4; i++) pop();

        // R4: length 3
        do_reset();
        blk_m = 6'd2;
        send_ok(8'h31); send_ok(8'h32);
        check("R4 wait", {15'd0, irq}, 16'd0);
        send_ok(8'h33);
        check("R4 pkt_end", {14'd0, irq, pkt_end}, 16'b11);
        for (int i = 0; i < 3; i++) pop();

        // R7 and R10: overrun
        do_reset();
        send_ok(8'h11);
        send_ok(8'h22);
        check("R7 ovr_err", {15'd0, ovr_err}, 16'd1);
        check("R7 kept first", {8'd0, rd_data}, 16'h0011);
        pop();
        check("R7 second lost", {15'd0, irq}, 16'd0);
        send_ok(8'h23);
        check("R10 sticky", {15'd0, ovr_err}, 16'd1);
        check("R10 rx continues", {8'd0, rd_data}, 16'h0023);
        pop();
        pulse_clr();
        check("R10 clear", {15'd0, ovr_err}, 16'd0);

        // R6: read before event ignored
        do_reset();
        blk_m = 6'd1;
        send_ok(8'h44);
        pop();
        send_ok(8'h55);
        check("R6 pkt_end", {15'd0, pkt_end}, 16'd1);
        check("R6 early read ignored", {8'd0, rd_data}, 16'h0044);
        pop();
        check("R6 second", {8'd0, rd_data}, 16'h0055);
        pop();

        // R9: block check bytes
        do_reset();
        blk_m = 6'd1; crc_en = 1'b1;
        crc = ref_crc(ref_crc(16'hFFFF, 8'h12), 8'h34);
        send_ok(8'h12); send_ok(8'h34);
        check("R9 pkt_end before check", {15'd0, pkt_end}, 16'd1);
        pop(); pop();
        send_ok(crc[15:8]); send_ok(crc[7:0]);
        check("R9 good crc", {15'd0, crc_err}, 16'd0);
        check("R9 check not stored", {15'd0, irq}, 16'd0);
        send_ok(8'h12); send_ok(8'h34);
        pop(); pop();
        send_ok(crc[15:8]); send_ok(crc[7:0] ^ 8'h01);
        check("R9 bad crc", {15'd0, crc_err}, 16'd1);

        // R11, R12, R3: addressed mode, parity on
        do_reset();
        wake_en = 1'b1; par_en = 1'b1; par_even = 1'b0; station = 8'h5A;
        send_char(8'h33, 1'b1, par_of(8'h33, 1'b0), 1'b1);
        check("R11 mismatch", {15'd0, wake_hold}, 16'd0);
        send_char(8'h77, 1'b0, par_of(8'h77, 1'b0), 1'b1);
        check("R11 ignored", {15'd0, irq}, 16'd0);
        send_char(8'h5A, 1'b1, par_of(8'h5A, 1'b0), 1'b1);
        check("R11 match", {14'd0, wake_hold, irq}, 16'b10);
        send_char(8'h99, 1'b0, par_of(8'h99, 1'b0), 1'b1);
        check("R3 wake parity order", {7'd0, par_err, rd_data}, 16'h0099);
        check("R11 stored", {15'd0, pkt_end}, 16'd1);
        pop();
        check("R12 hold dropped", {15'd0, wake_hold}, 16'd0);
        send_char(8'h98, 1'b0, par_of(8'h98, 1'b0), 1'b1);
        check("R12 closed", {15'd0, irq}, 16'd0);

        // R13: receive disable
        do_reset();
        rx_en = 1'b0;
        send_ok(8'h66);
        check("R13 disabled", {15'd0, irq}, 16'd0);
        rx_en = 1'b1;
        send_ok(8'h67);
        check("R13 enabled", {8'd0, rd_data}, 16'h0067);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule